// File: doc/BRIEF.md
# HDLC Command Controller

This block lets a host issue one command at a time to a remote slow-control chip over a two-bit serial lane and collect the reply. The host writes a 32-bit payload and then writes a go bit. The block wraps the payload in an HDLC frame (flag, payload, CRC-16 check field, flag) with zero-bit stuffing, and shifts it out two bits per transmit clock cycle. It then watches the receive lane, removes stuffing, checks the CRC of the incoming 5-byte reply and presents that reply to the host. Completion raises a status bit and an interrupt.

Three clock domains meet here. The host bus runs on its own clock, and the serial transmit and receive sides each have their own clock. The go request crosses to the transmit side as a toggle. Reply and error events come back to the bus side as toggles. Register-sized data crosses only while it is held stable.

Top module: `hdlc_cmd_ctrl`

## Requirements
- R1: After reset, status (offset 4) reads 0, enable (offset 24) reads 0, the interrupt is low and no frame is sent; the transmit lane carries idle flags 0x7E.
- R2: With enable set, a go starts one frame on the transmit lane. The frame is an opening flag, then the 32-bit word at offset 12 starting at bit 0, then the complement of a CRC-16 (reflected polynomial 0x8408, preset 0xFFFF) starting at its bit 0, then a closing flag. Each clock carries two bits, and the earlier bit is on lane bit 1.
- R3: Between flags, a 0 is inserted after every five consecutive 1s on transmit and removed on receive, and an inserted bit may fall in either lane position.
- R4: A reply is accepted when its de-stuffed length is 40 data bits plus 16 check bits and its CRC residue is 0xF0B8. Data bit 0 is the first bit received. Bits 31:0 read at offset 12 and bits 39:32 at offset 8 bits 7:0. Status bit 0 (done) is set and status bit 1 (busy) is cleared.
- R5: A reply with a bad CRC residue or a wrong length is dropped. It sets status bit 2, leaves the data registers unchanged and does not set done.
- R6: Writing offset 0 with bit 0 set while busy is ignored and sets status bit 3 (overrun). While busy, writes to offset 12 are ignored, so exactly one frame with the original payload is sent.
- R7: The interrupt is high exactly while done is set. Reading status returns bits 0, 2 and 3 and then clears them and the interrupt. Busy is not cleared by the read.
- R8: With enable at 0, the transmit lane sends only flags and a go stays pending, and incoming replies are ignored. Setting enable later releases the pending frame.
- R9: A read returns its data with the read-valid strobe exactly one bus clock after the read strobe, and read-valid stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | host bus clock |
| rst_n | input | 1 | asynchronous active-low reset for all domains |
| mm_addr | input | AW | register byte address |
| mm_write | input | 1 | write strobe |
| mm_wdata | input | 32 | write data |
| mm_read | input | 1 | read strobe |
| mm_rdata | output | 32 | read data |
| mm_rvalid | output | 1 | read data valid |
| mm_irq | output | 1 | reply-received interrupt |
| tx_clk | input | 1 | transmit serial clock |
| ser_tx | output | 2 | transmit symbol, bit 1 sent first |
| rx_clk | input | 1 | receive serial clock |
| ser_rx | input | 2 | receive symbol, bit 1 received first |

## Verification
Commands are tried with payloads and replies of mixed bits, all zeros, all ones and repeated 0x7E bytes. Mixed and zero patterns check bit order and CRC placement without stuffing. All-ones and flag-like bytes force stuffed bits in both lane positions, and a wrong decision about stuff boundaries would break the check field or the length. Further cases issue a second go and a payload overwrite while busy, a reply with one flipped data bit, and a reply sent while disabled. These show that overrun, CRC error and enable each affect only their own effect and leave the stored reply untouched.

// File: rtl/hdlc_cmd_ctrl.sv
module hdlc_cmd_ctrl #(
  parameter int AW = 8
) (
  input  logic          bus_clk,
  input  logic          rst_n,
  input  logic [AW-1:0] mm_addr,
  input  logic          mm_write,
  input  logic [31:0]   mm_wdata,
  input  logic          mm_read,
  output logic [31:0]   mm_rdata,
  output logic          mm_rvalid,
  output logic          mm_irq,
  input  logic          tx_clk,
  output logic [1:0]    ser_tx,
  input  logic          rx_clk,
  input  logic [1:0]    ser_rx
);
  localparam int TXB = 32;
  localparam int RXB = 40;
  localparam int FCS = 16;
  localparam int LAG = 7;
  localparam int SHW = RXB + FCS + 8;
  localparam int RX_END = RXB + FCS + LAG;
  localparam logic [15:0] POLY = 16'h8408;
  localparam logic [15:0] GOOD = 16'hF0B8;
  localparam logic [1:0] PH_IDLE = 2'd0, PH_PAY = 2'd1, PH_FCS = 2'd2;
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_STAT = AW'(4), A_HI = AW'(8),
                            A_LO = AW'(12), A_EN = AW'(24);

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return (c >> 1) ^ (((c[0] ^ b) == 1'b1) ? POLY : 16'h0000);
  endfunction

  // receive-domain results seen by the bus side
  logic rx_tgl, er_tgl;
  logic [RXB-1:0] rx_buf;

  // bus domain
  logic pend, done, cerr, ovr, en, go_t;
  logic [31:0] tx_lo;
  logic [RXB-1:0] rx_cap;
  logic [2:0] dn_s, er_s;
  logic rx_evt, er_evt, wr_go, rd_st;

  assign rx_evt = dn_s[2] ^ dn_s[1];
  assign er_evt = er_s[2] ^ er_s[1];
  assign wr_go  = mm_write && mm_addr == A_CTRL && mm_wdata[0];
  assign rd_st  = mm_read && mm_addr == A_STAT;
  assign mm_irq = done;

  always_ff @(posedge bus_clk or negedge rst_n)
    if (!rst_n) begin
      pend <= 1'b0; done <= 1'b0; cerr <= 1'b0; ovr <= 1'b0; en <= 1'b0; go_t <= 1'b0;
      tx_lo <= '0; rx_cap <= '0; dn_s <= '0; er_s <= '0;
      mm_rdata <= '0; mm_rvalid <= 1'b0;
    end else begin
      dn_s <= {dn_s[1:0], rx_tgl};
      er_s <= {er_s[1:0], er_tgl};
      if (mm_write && mm_addr == A_EN) en <= mm_wdata[0];
      if (mm_write && mm_addr == A_LO && !pend) tx_lo <= mm_wdata;
      if (rd_st) begin done <= 1'b0; cerr <= 1'b0; ovr <= 1'b0; end
      if (wr_go) begin
        if (pend) ovr <= 1'b1;
        else begin pend <= 1'b1; go_t <= ~go_t; end
      end
      if (rx_evt) begin done <= 1'b1; pend <= 1'b0; rx_cap <= rx_buf; end
      if (er_evt) cerr <= 1'b1;
      mm_rvalid <= mm_read;
      if (mm_read)
        case (mm_addr)
          A_STAT:  mm_rdata <= {28'd0, ovr, cerr, pend, done};
          A_HI:    mm_rdata <= 32'(rx_cap[RXB-1:32]);
          A_LO:    mm_rdata <= rx_cap[31:0];
          A_EN:    mm_rdata <= {31'd0, en};
          default: mm_rdata <= '0;
        endcase
    end

  // transmit domain
  logic [1:0] go_s, en_ts, t_ph, n_ph, t_sym;
  logic go_ack, n_ack;
  logic [5:0] t_cnt, n_cnt;
  logic [2:0] t_ones, n_ones;
  logic [15:0] t_crc, n_crc;

  always_comb begin
    logic b;
    b = 1'b0;
    n_ph = t_ph; n_cnt = t_cnt; n_ones = t_ones; n_crc = t_crc; n_ack = go_ack; t_sym = '0;
    for (int i = 1; i >= 0; i--) begin
      if (!en_ts[1] && n_ph != PH_IDLE) begin n_ph = PH_IDLE; n_cnt = '0; n_ones = '0; end
      if (n_ones == 3'd5) begin
        b = 1'b0; n_ones = '0;
      end else if (n_ph == PH_IDLE) begin
        b = (n_cnt[2:0] != 3'd0) && (n_cnt[2:0] != 3'd7);
        n_ones = '0;
        if (n_cnt[2:0] == 3'd7 && en_ts[1] && go_s[1] != n_ack) begin
          n_ph = PH_PAY; n_cnt = '0; n_crc = '1; n_ack = go_s[1];
        end else n_cnt = {3'b000, n_cnt[2:0] + 3'd1};
      end else begin
        if (n_ph == PH_PAY) begin b = tx_lo[n_cnt[4:0]]; n_crc = crc_step(n_crc, b); end
        else b = ~n_crc[n_cnt[3:0]];
        n_ones = b ? n_ones + 3'd1 : 3'd0;
        n_cnt = n_cnt + 6'd1;
        if (n_ph == PH_PAY && n_cnt == 6'(TXB)) begin n_ph = PH_FCS; n_cnt = '0; end
        else if (n_ph == PH_FCS && n_cnt == 6'(FCS)) begin n_ph = PH_IDLE; n_cnt = '0; end
      end
      t_sym[i] = b;
    end
  end

  always_ff @(posedge tx_clk or negedge rst_n)
    if (!rst_n) begin
      go_s <= '0; en_ts <= '0; go_ack <= 1'b0; t_ph <= PH_IDLE; t_cnt <= '0;
      t_ones <= '0; t_crc <= '1; ser_tx <= '0;
    end else begin
      go_s <= {go_s[0], go_t}; en_ts <= {en_ts[0], en}; go_ack <= n_ack;
      t_ph <= n_ph; t_cnt <= n_cnt; t_ones <= n_ones; t_crc <= n_crc; ser_tx <= t_sym;
    end

  // receive domain
  logic [1:0] en_rs;
  logic [2:0] r_ones, m_ones;
  logic [6:0] r_cnt, m_cnt;
  logic [SHW-1:0] r_sh, m_sh;
  logic [15:0] r_crc, m_crc;
  logic r_sync, m_sync, m_rt, m_et;
  logic [RXB-1:0] m_buf;

  always_comb begin
    logic b;
    m_ones = r_ones; m_cnt = r_cnt; m_sh = r_sh; m_crc = r_crc; m_sync = r_sync;
    m_buf = rx_buf; m_rt = rx_tgl; m_et = er_tgl;
    for (int i = 1; i >= 0; i--) begin
      b = ser_rx[i];
      if (m_ones == 3'd6 && !b) begin
        if (m_sync && m_cnt == 7'(RX_END) && m_crc == GOOD) begin
          m_buf = m_sh[RXB:1]; m_rt = ~m_rt;
        end else if (m_sync && m_cnt != 7'(LAG)) m_et = ~m_et;
        m_sync = 1'b1; m_cnt = '0; m_crc = '1; m_ones = '0;
      end else if (m_ones == 3'd5 && !b) begin
        m_ones = '0;
      end else begin
        if (m_cnt >= 7'(LAG)) m_crc = crc_step(m_crc, m_sh[SHW-LAG]);
        m_sh = {b, m_sh[SHW-1:1]};
        if (m_cnt != 7'h7F) m_cnt = m_cnt + 7'd1;
        if (!b) m_ones = '0;
        else if (m_ones == 3'd6) begin m_ones = 3'd7; m_sync = 1'b0; end
        else if (m_ones != 3'd7) m_ones = m_ones + 3'd1;
      end
    end
    if (!en_rs[1]) begin
      m_ones = '0; m_cnt = r_cnt; m_sh = r_sh; m_crc = r_crc; m_sync = 1'b0;
      m_buf = rx_buf; m_rt = rx_tgl; m_et = er_tgl;
    end
  end

  always_ff @(posedge rx_clk or negedge rst_n)
    if (!rst_n) begin
      en_rs <= '0; r_ones <= '0; r_cnt <= '0; r_sh <= '0; r_crc <= '1; r_sync <= 1'b0;
      rx_buf <= '0; rx_tgl <= 1'b0; er_tgl <= 1'b0;
    end else begin
      en_rs <= {en_rs[0], en};
      r_ones <= m_ones; r_cnt <= m_cnt; r_sh <= m_sh; r_crc <= m_crc; r_sync <= m_sync;
      rx_buf <= m_buf; rx_tgl <= m_rt; er_tgl <= m_et;
    end
endmodule

module hdlc_cmd_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          bus_clk,
  input logic          tx_clk,
  input logic          rst_n,
  input logic          mm_read,
  input logic [AW-1:0] mm_addr,
  input logic          mm_rvalid,
  input logic          mm_irq,
  input logic          pend,
  input logic          rx_evt,
  input logic          tx_en,
  input logic [1:0]    t_ph,
  input logic [2:0]    t_ones,
  input logic [5:0]    t_cnt
);
  a_r9_rvalid_after_read: assert property (@(posedge bus_clk) disable iff (!rst_n)
    mm_read |=> mm_rvalid);
  a_r9_no_stray_rvalid: assert property (@(posedge bus_clk) disable iff (!rst_n)
    !mm_read |=> !mm_rvalid);
  a_r7_status_read_clears_irq: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (mm_read && mm_addr == AW'(4) && !rx_evt) |=> !mm_irq);
  a_r7_irq_needs_reply: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (!mm_irq && !rx_evt) |=> !mm_irq);
  a_r6_busy_until_reply: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (pend && !rx_evt) |=> pend);
  a_r3_run_limit: assert property (@(posedge tx_clk) disable iff (!rst_n)
    t_ones <= 3'd5);
  a_r8_disabled_idle: assert property (@(posedge tx_clk) disable iff (!rst_n)
    !tx_en |=> t_ph == 2'd0);
  a_r2_fcs_span: assert property (@(posedge tx_clk) disable iff (!rst_n)
    t_ph == 2'd2 |-> t_cnt < 6'd16);
endmodule

bind hdlc_cmd_ctrl hdlc_cmd_ctrl_chk #(.AW(AW)) u_chk (
  .bus_clk(bus_clk), .tx_clk(tx_clk), .rst_n(rst_n), .mm_read(mm_read),
  .mm_addr(mm_addr), .mm_rvalid(mm_rvalid), .mm_irq(mm_irq), .pend(pend),
  .rx_evt(rx_evt), .tx_en(en_ts[1]), .t_ph(t_ph), .t_ones(t_ones), .t_cnt(t_cnt));

// File: tb/hdlc_cmd_ctrl_test.sv
`timescale 1ns/1ps
module hdlc_cmd_ctrl_test;
  logic bus_clk = 0, tx_clk = 0, rx_clk = 0, rst_n = 0;
  logic [7:0] mm_addr = '0;
  logic mm_write = 0, mm_read = 0;
  logic [31:0] mm_wdata = '0;
  logic [31:0] mm_rdata;
  logic mm_rvalid, mm_irq;
  logic [1:0] ser_tx;
  logic [1:0] ser_rx = 2'b00;

  always #4 bus_clk = ~bus_clk;
  always #12.5 tx_clk = ~tx_clk;
  always #12 rx_clk = ~rx_clk;

  hdlc_cmd_ctrl #(.AW(8)) uut (
    .bus_clk(bus_clk), .rst_n(rst_n), .mm_addr(mm_addr), .mm_write(mm_write),
    .mm_wdata(mm_wdata), .mm_read(mm_read), .mm_rdata(mm_rdata), .mm_rvalid(mm_rvalid),
    .mm_irq(mm_irq), .tx_clk(tx_clk), .ser_tx(ser_tx), .rx_clk(rx_clk), .ser_rx(ser_rx));

  int n_chk = 0, n_bad = 0, n_frames = 0, ones = 0;
  bit synced = 0;
  logic [7:0] win = '0;
  bit col[$];
  bit rxq[$];
  logic [31:0] exp_tx[$];
  logic [39:0] exp_rx[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_bit(input logic [15:0] c, input bit b);
    logic [15:0] t;
    t = c;
    t[0] = t[0] ^ b;
    return t[0] ? ((t >> 1) ^ 16'h8408) : (t >> 1);
  endfunction

  // monitor: decodes transmit frames and pops the expected payload
  task automatic mon_bit(input bit b);
    win = {win[6:0], b};
    if (win == 8'h7E) begin
      if (synced && col.size() != 7) begin
        logic [15:0] c;
        logic [31:0] p;
        c = 16'hFFFF; p = '0;
        for (int k = 0; k < col.size() - 7; k++) begin
          c = crc_bit(c, col[k]);
          if (k < 32) p[k] = col[k];
        end
        n_frames++;
        chk("R2 frame length", 64'(col.size() - 7), 64'd48);
        chk("R2 check field residue", 64'(c), 64'hF0B8);
        if (exp_tx.size() == 0) chk("R6 unexpected extra frame", 64'd1, 64'd0);
        else chk("R2 payload", 64'(p), 64'(exp_tx.pop_front()));
      end
      synced = 1; col.delete(); ones = 0;
    end else if (ones == 5 && !b) ones = 0;
    else begin
      col.push_back(b);
      ones = b ? ones + 1 : 0;
    end
  endtask

  initial forever begin
    @(negedge tx_clk);
    if (rst_n) begin mon_bit(ser_tx[1]); mon_bit(ser_tx[0]); end
  end

  // receive lane driver: idles with flags
  initial forever begin
    @(negedge rx_clk);
    if (rxq.size() < 2) for (int k = 0; k < 8; k++) rxq.push_back(k != 0 && k != 7);
    ser_rx[1] = rxq.pop_front();
    ser_rx[0] = rxq.pop_front();
  end

  task automatic send_reply(input logic [39:0] v, input bit bad);
    bit raw[$];
    logic [15:0] c;
    int run;
    c = 16'hFFFF;
    for (int k = 0; k < 40; k++) begin raw.push_back(v[k]); c = crc_bit(c, v[k]); end
    for (int k = 0; k < 16; k++) raw.push_back(~c[k]);
    if (bad) raw[3] = ~raw[3];
    for (int k = 0; k < 8; k++) rxq.push_back(k != 0 && k != 7);
    run = 0;
    foreach (raw[k]) begin
      rxq.push_back(raw[k]);
      if (raw[k]) begin
        run++;
        if (run == 5) begin rxq.push_back(1'b0); run = 0; end
      end else run = 0;
    end
    for (int k = 0; k < 8; k++) rxq.push_back(k != 0 && k != 7);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge bus_clk); mm_addr = a; mm_wdata = d; mm_write = 1;
    @(negedge bus_clk); mm_write = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge bus_clk); mm_addr = a; mm_read = 1;
    @(negedge bus_clk); mm_read = 0;
    chk("R9 read valid one cycle after read", 64'(mm_rvalid), 64'd1);
    d = mm_rdata;
  endtask

  task automatic wait_frames(input int target);
    for (int k = 0; k < 4000 && n_frames < target; k++) @(negedge bus_clk);
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 4000 && !mm_irq; k++) @(negedge bus_clk);
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 4000 && rxq.size() > 8; k++) @(negedge bus_clk);
    repeat (60) @(negedge bus_clk);
  endtask

  // driver: one full command, expected items go to the queues
  task automatic run_cmd(input string tag, input logic [31:0] pl, input logic [39:0] rp);
    logic [31:0] d;
    logic [39:0] e;
    int f0;
    f0 = n_frames;
    bus_wr(8'd12, pl);
    exp_tx.push_back(pl);
    bus_wr(8'd0, 32'd1);
    wait_frames(f0 + 1);
    chk({tag, " one frame sent"}, 64'(n_frames), 64'(f0 + 1));
    send_reply(rp, 0);
    exp_rx.push_back(rp);
    wait_irq();
    chk({tag, " R7 interrupt on reply"}, 64'(mm_irq), 64'd1);
    bus_rd(8'd4, d);
    chk({tag, " R4 status done, not busy"}, 64'(d), 64'h1);
    chk({tag, " R7 interrupt cleared by status read"}, 64'(mm_irq), 64'd0);
    e = exp_rx.pop_front();
    bus_rd(8'd8, d);
    chk({tag, " R4 reply high byte"}, 64'(d), 64'(e[39:32]));
    bus_rd(8'd12, d);
    chk({tag, " R4 reply low word"}, 64'(d), 64'(e[31:0]));
    wait_drain();
  endtask

  initial begin
    repeat (5) @(negedge bus_clk);
    rst_n = 1;
    repeat (5) @(negedge bus_clk);
  end

  initial begin
    logic [31:0] d;
    int f0;
    wait (rst_n);
    repeat (10) @(negedge bus_clk);
    chk("R1 interrupt low after reset", 64'(mm_irq), 64'd0);
    chk("R9 no read valid while idle", 64'(mm_rvalid), 64'd0);
    bus_rd(8'd4, d); chk("R1 status after reset", 64'(d), 64'd0);
    bus_rd(8'd24, d); chk("R1 enable after reset", 64'(d), 64'd0);

    // R8: go while disabled stays pending, replies ignored
    bus_wr(8'd12, 32'hCAFEF00D);
    exp_tx.push_back(32'hCAFEF00D);
    bus_wr(8'd0, 32'd1);
    repeat (300) @(negedge bus_clk);
    chk("R8 no frame while disabled", 64'(n_frames), 64'd0);
    send_reply(40'h11_1111_1111, 0);
    wait_drain();
    chk("R8 reply ignored while disabled", 64'(mm_irq), 64'd0);
    bus_rd(8'd4, d); chk("R8 status busy only", 64'(d), 64'h2);
    bus_wr(8'd24, 32'd1);
    wait_frames(1);
    chk("R8 pending frame released by enable", 64'(n_frames), 64'd1);
    send_reply(40'hA5_0102_0304, 0);
    wait_irq();
    bus_rd(8'd4, d); chk("R4 status after first reply", 64'(d), 64'h1);
    bus_rd(8'd8, d); chk("R4 high byte", 64'(d), 64'hA5);
    bus_rd(8'd12, d); chk("R4 low word", 64'(d), 64'h0102_0304);
    bus_rd(8'd4, d); chk("R7 status cleared by read", 64'(d), 64'd0);
    wait_drain();

    run_cmd("R3 all ones", 32'hFFFF_FFFF, 40'hFF_FFFF_FFFF);
    run_cmd("R2 all zeros", 32'h0000_0000, 40'h00_0000_0000);
    run_cmd("R3 flag-like bytes", 32'h7E7E_7E7E, 40'h3E_7E7E_F81F);

    // R6: second go and payload overwrite while busy
    f0 = n_frames;
    bus_wr(8'd12, 32'h1357_9BDF);
    exp_tx.push_back(32'h1357_9BDF);
    bus_wr(8'd0, 32'd1);
    bus_wr(8'd12, 32'h2468_ACE0);
    bus_wr(8'd0, 32'd1);
    bus_rd(8'd4, d); chk("R6 busy and overrun", 64'(d), 64'hA);
    wait_frames(f0 + 1);
    repeat (600) @(negedge bus_clk);
    chk("R6 exactly one frame", 64'(n_frames), 64'(f0 + 1));
    send_reply(40'h00_55AA_55AA, 0);
    wait_irq();
    bus_rd(8'd4, d); chk("R6 overrun cleared, done set", 64'(d), 64'h1);
    wait_drain();

    // R5: corrupted reply
    f0 = n_frames;
    bus_wr(8'd12, 32'h0BAD_BEEF);
    exp_tx.push_back(32'h0BAD_BEEF);
    bus_wr(8'd0, 32'd1);
    wait_frames(f0 + 1);
    send_reply(40'hC3_3C3C_C3C3, 1);
    wait_drain();
    chk("R5 no interrupt on bad reply", 64'(mm_irq), 64'd0);
    bus_rd(8'd4, d); chk("R5 busy and crc error", 64'(d), 64'h6);
    bus_rd(8'd12, d); chk("R5 data unchanged", 64'(d), 64'h55AA_55AA);
    send_reply(40'hC3_3C3C_C3C3, 0);
    wait_irq();
    bus_rd(8'd4, d); chk("R5 good reply after error", 64'(d), 64'h1);
    bus_rd(8'd12, d); chk("R4 low word after recovery", 64'(d), 64'h3C3C_C3C3);
    chk("R2 all expected frames seen", 64'(exp_tx.size()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge bus_clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1-run actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule